// File: doc/BRIEF.md
# SPI Register-Access Target Interface

This block is the peripheral side of an SPI link. It lets an external host read and write a byte-wide memory that uses 16-bit addresses. The serial pins are brought into the system clock domain through synchronizers. The block detects clock and select edges there, assembles bytes MSB first in SPI mode 0, and drives a simple synchronous memory port. That port has a one-cycle read latency.

The host works with two commands. A frame that opens with 0xF0 carries an address, high byte first, and may carry write data. Each data byte is stored at the next address. A frame that opens with 0xF1 streams bytes back from the address held in the block. The reply starts at the second byte position, and the first position is a dummy. Because of this, a read normally takes two chip-select frames: one to set the address and one to fetch the data. The held address stays valid from one frame to the next.

Every completed data byte moves the held address on by one, and the address wraps at the top of the address space. Releasing chip select drops any partial byte and returns the decoder to its idle state.

Top module: `spi_reg_target`

## Requirements
- R1: After reset, spi_miso is 0 and neither mem_we nor mem_re is asserted.
- R2: In a frame whose first byte is 0xF0, the next two bytes form the address, high byte first. Each further byte is written once to mem_addr = address + k, where k counts from 0 in frame order. A 4-byte frame writes exactly one byte.
- R3: A 0xF0 frame of exactly 3 bytes performs no write. The address it carries becomes the start address of the next read.
- R4: In a frame whose first byte is 0xF1, MISO is 0 during the command byte. From byte position 2 onward, MISO carries the byte stored at the held address, MSB first. MISO changes after SCLK falling edges and is stable at rising edges.
- R5: Each further byte of a read frame returns the next consecutive address. Each completed data byte advances the held address by one. A following 0xF1 frame with no new address continues from where the previous one stopped.
- R6: The address wraps from 0xFFFF to 0x0000 during write and read bursts.
- R7: A frame whose first byte is neither 0xF0 nor 0xF1 causes no write. MISO stays 0 for that frame, and the held address is unchanged.
- R8: Raising CS_n in the middle of a byte discards that byte, so no write occurs for it. The decoder returns to idle. The held address keeps the value it last reached, and a frame cut off inside its address bytes leaves it unchanged.
- R9: MISO is 0 throughout write frames and while CS_n is high.
- R10: A single frame of 1024 bytes, command and address bytes included, writes all 1021 data bytes to consecutive addresses.
- R11: A new frame is decoded correctly after a CS_n high time of only 3 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_re | output | 1 | Memory read strobe, data expected next cycle |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |

## Verification
The assertions check on every cycle that no read and write strobe coincide and that no memory access happens outside a selected frame. They also check that MISO falls to 0 once select is released, and that successive writes or reads within one frame step the address by exactly one, including across the wrap. Only the bench scenarios can show the rest. That covers correct command decoding, the high-first address order, and the dummy first read byte. It also covers address persistence across frames, the effect of aborting mid-byte or mid-address, ignored commands, the full 1024-byte frame, and short gaps between frames.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_SET_WRITE = 8'hF0;
    localparam logic [BYTE_W-1:0] OP_READ      = 8'hF1;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    function automatic tgt_state_e decode_op(logic [BYTE_W-1:0] op);
        if (op == OP_SET_WRITE)
            return ST_ADDR;
        else if (op == OP_READ)
            return ST_READ;
        else
            return ST_SKIP;
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_on,
    output logic mosi_bit
);
    logic [STAGES-1:0] sclk_ff;
    logic [STAGES-1:0] cs_ff;
    logic [STAGES-1:0] mosi_ff;
    logic              sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_ff <= '0;
            cs_ff   <= '1;
            mosi_ff <= '0;
            sclk_d  <= 1'b0;
        end else begin
            sclk_ff <= {sclk_ff[STAGES-2:0], sclk};
            cs_ff   <= {cs_ff[STAGES-2:0], cs_n};
            mosi_ff <= {mosi_ff[STAGES-2:0], mosi};
            sclk_d  <= sclk_ff[STAGES-1];
        end
    end

    assign sclk_rise = sclk_ff[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_ff[STAGES-1] & sclk_d;
    assign cs_on     = ~cs_ff[STAGES-1];
    assign mosi_bit  = mosi_ff[STAGES-1];

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
    import spi_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_on,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_bit,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output rx_byte_t          rx_evt,
    output logic              miso
);
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst || !cs_on) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rx_evt  <= '0;
        end else begin
            rx_evt.valid <= 1'b0;
            if (sclk_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(BYTE_W-1))
                    rx_evt <= '{valid: 1'b1, data: {rx_sr, mosi_bit}};
            end
            // a byte boundary never shifts: the next byte is loaded there
            if (tx_load)
                tx_sr <= tx_data;
            else if (sclk_fall && bit_cnt != '0)
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso = tx_sr[BYTE_W-1];

endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
    import spi_tgt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_on,
    input  rx_byte_t          rx_evt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              tx_load
);
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    tgt_state_e               state;
    logic [ADDR_W-1:0]        addr_q;
    logic [ADDR_W-BYTE_W-1:0] addr_sh;
    logic [CNT_W-1:0]         abyte_cnt;
    logic [ADDR_W-1:0]        addr_next;
    logic [ADDR_W-1:0]        addr_inc;

    assign addr_next = {addr_sh, rx_evt.data};
    assign addr_inc  = addr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CMD;
            addr_q    <= '0;
            addr_sh   <= '0;
            abyte_cnt <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            tx_load   <= 1'b0;
        end else begin
            mem_we  <= 1'b0;
            mem_re  <= 1'b0;
            tx_load <= mem_re & cs_on;
            if (!cs_on) begin
                state     <= ST_CMD;
                abyte_cnt <= '0;
            end else if (rx_evt.valid) begin
                unique case (state)
                    ST_CMD: begin
                        state     <= decode_op(rx_evt.data);
                        abyte_cnt <= '0;
                        if (decode_op(rx_evt.data) == ST_READ) begin
                            mem_re   <= 1'b1;
                            mem_addr <= addr_q;
                        end
                    end
                    ST_ADDR: begin
                        addr_sh   <= addr_next[ADDR_W-BYTE_W-1:0];
                        abyte_cnt <= abyte_cnt + 1'b1;
                        if (abyte_cnt == CNT_W'(ADDR_BYTES - 1)) begin
                            addr_q <= addr_next;
                            state  <= ST_WRITE;
                        end
                    end
                    ST_WRITE: begin
                        mem_we    <= 1'b1;
                        mem_addr  <= addr_q;
                        mem_wdata <= rx_evt.data;
                        addr_q    <= addr_inc;
                    end
                    ST_READ: begin
                        // prefetch the following byte at each boundary
                        mem_re   <= 1'b1;
                        mem_addr <= addr_inc;
                        addr_q   <= addr_inc;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
    import spi_tgt_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic     sclk_rise;
    logic     sclk_fall;
    logic     cs_on;
    logic     mosi_bit;
    logic     tx_load;
    rx_byte_t rx_evt;

    spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_on     (cs_on),
        .mosi_bit  (mosi_bit)
    );

    spi_tgt_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_on     (cs_on),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_bit  (mosi_bit),
        .tx_load   (tx_load),
        .tx_data   (mem_rdata),
        .rx_evt    (rx_evt),
        .miso      (spi_miso)
    );

    spi_tgt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_on     (cs_on),
        .rx_evt    (rx_evt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .tx_load   (tx_load)
    );

endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_on,
    input logic              miso,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);
    logic              have_w;
    logic              have_r;
    logic [ADDR_W-1:0] last_w;
    logic [ADDR_W-1:0] last_r;

    always_ff @(posedge clk) begin
        if (rst || !cs_on) begin
            have_w <= 1'b0;
            have_r <= 1'b0;
            last_w <= '0;
            last_r <= '0;
        end else begin
            if (mem_we) begin
                have_w <= 1'b1;
                last_w <= mem_addr;
            end
            if (mem_re) begin
                have_r <= 1'b1;
                last_r <= mem_addr;
            end
        end
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R7
    we_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(cs_on));

    // R4
    re_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> $past(cs_on));

    // R9
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_on |=> !miso);

    // R6
    write_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && have_w) |-> (mem_addr == ADDR_W'(last_w + 1'b1)));

    // R5
    read_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && have_r) |-> (mem_addr == ADDR_W'(last_r + 1'b1)));

endmodule

bind spi_reg_target spi_tgt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_on    (cs_on),
    .miso     (spi_miso),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr)
);

// File: tb/tb_spi_reg_target.sv
module tb_spi_reg_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int LOG_DEPTH  = 1200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = 8'h00;

    int n_checks = 0;
    int n_err    = 0;

    logic [15:0] log_a [0:LOG_DEPTH-1];
    logic [7:0]  log_d [0:LOG_DEPTH-1];
    int          log_n = 0;

    logic [7:0] ftx [0:1023];
    logic [7:0] frx [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_target dut (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return 8'(a[7:0] + a[15:8] * 8'd7 + 8'h3C);
    endfunction

    function automatic logic [7:0] dat(input int seed, input int i);
        return 8'(seed + i * 13);
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= pat(mem_addr);
        if (mem_we && log_n < LOG_DEPTH) begin
            log_a[log_n] <= mem_addr;
            log_d[log_n] <= mem_wdata;
            log_n <= log_n + 1;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input int nbytes, input int extra_bits, input int gap);
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_cyc(HALF);
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                spi_mosi = ftx[b][i];
                wait_cyc(HALF);
                frx[b][i] = spi_miso;
                spi_sclk = 1'b1;
                wait_cyc(HALF);
                spi_sclk = 1'b0;
            end
        end
        for (int i = 0; i < extra_bits; i++) begin
            spi_mosi = 1'b1;
            wait_cyc(HALF);
            spi_sclk = 1'b1;
            wait_cyc(HALF);
            spi_sclk = 1'b0;
        end
        wait_cyc(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        wait_cyc(gap);
    endtask

    task automatic set_hdr(input logic [7:0] op, input logic [15:0] a);
        ftx[0] = op;
        ftx[1] = a[15:8];
        ftx[2] = a[7:0];
    endtask

    task automatic write_frame(input string tag, input logic [15:0] a, input int n, input int seed);
        int base;
        base = log_n;
        set_hdr(8'hF0, a);
        for (int i = 0; i < n; i++) ftx[3+i] = dat(seed, i);
        run_frame(3 + n, 0, 20);
        chk(tag, log_n - base, n);
        for (int i = 0; i < n; i++) begin
            chk(tag, {16'h0, log_a[base+i]}, {16'h0, 16'(a + 16'(i))});
            chk(tag, {24'h0, log_d[base+i]}, {24'h0, dat(seed, i)});
        end
        for (int i = 0; i < 3 + n; i++)
            chk("R9", {31'h0, |frx[i]}, 32'h0);
    endtask

    task automatic read_frame(input string tag, input logic [15:0] a, input int n);
        ftx[0] = 8'hF1;
        for (int i = 1; i <= n; i++) ftx[i] = 8'h00;
        run_frame(1 + n, 0, 20);
        chk("R4", {24'h0, frx[0]}, 32'h0);
        for (int i = 0; i < n; i++)
            chk(tag, {24'h0, frx[1+i]}, {24'h0, pat(16'(a + 16'(i)))});
    endtask

    task automatic set_addr(input logic [15:0] a);
        int base;
        base = log_n;
        set_hdr(8'hF0, a);
        run_frame(3, 0, 20);
        chk("R3", log_n - base, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(3);
        // R1 reset state
        chk("R1", {31'h0, spi_miso}, 32'h0);
        chk("R1", {31'h0, mem_we}, 32'h0);
        chk("R1", {31'h0, mem_re}, 32'h0);

        // R2 single byte write frame
        write_frame("R2", 16'h1234, 1, 8'hAB);
        // R2 sweep of burst lengths; length 0 is the R3 case
        for (int len = 0; len <= 6; len++)
            write_frame("R2", 16'(16'h2000 + len * 16), len, len * 5);

        // R3 address-only frame, then R4 / R5 read burst
        set_addr(16'h4010);
        read_frame("R4", 16'h4010, 4);
        for (int len = 1; len <= 6; len++) begin
            set_addr(16'(16'h7000 + len * 32));
            read_frame("R5", 16'(16'h7000 + len * 32), len);
        end
        // R5 continuation without a new address
        read_frame("R5", 16'h70C6, 2);

        // R6 wrap on write and on read
        write_frame("R6", 16'hFFFE, 4, 8'h21);
        set_addr(16'hFFFF);
        read_frame("R6", 16'hFFFF, 3);

        // R7 unknown command byte is ignored
        base = log_n;
        ftx[0] = 8'h55; ftx[1] = 8'hF0; ftx[2] = 8'h12; ftx[3] = 8'h34; ftx[4] = 8'h56;
        run_frame(5, 0, 20);
        chk("R7", log_n - base, 0);
        for (int i = 0; i < 5; i++) chk("R7", {24'h0, frx[i]}, 32'h0);
        read_frame("R7", 16'h0002, 1);

        // R8 abort inside a write data byte
        base = log_n;
        set_hdr(8'hF0, 16'h3000);
        ftx[3] = 8'h11;
        run_frame(4, 4, 20);
        chk("R8", log_n - base, 1);
        chk("R8", {16'h0, log_a[base]}, 32'h3000);
        chk("R8", {24'h0, log_d[base]}, 32'h11);
        read_frame("R8", 16'h3001, 1);
        // R8 abort inside the address bytes leaves the address alone
        ftx[0] = 8'hF0; ftx[1] = 8'h50;
        run_frame(2, 3, 20);
        read_frame("R8", 16'h3002, 1);
        // R8 abort inside a read data byte
        ftx[0] = 8'hF1; ftx[1] = 8'h00;
        run_frame(2, 5, 20);
        chk("R8", {24'h0, frx[1]}, {24'h0, pat(16'h3003)});
        read_frame("R8", 16'h3004, 1);

        // R11 short gap between frames
        base = log_n;
        set_hdr(8'hF0, 16'h6000); ftx[3] = 8'hAA;
        run_frame(4, 0, 3);
        set_hdr(8'hF0, 16'h6010); ftx[3] = 8'hBB;
        run_frame(4, 0, 20);
        chk("R11", log_n - base, 2);
        chk("R11", {16'h0, log_a[base]}, 32'h6000);
        chk("R11", {16'h0, log_a[base+1]}, 32'h6010);
        chk("R11", {24'h0, log_d[base+1]}, 32'hBB);

        // R10 full 1024-byte frame
        write_frame("R10", 16'h8000, 1021, 7);
        set_addr(16'h80F0);
        read_frame("R10", 16'h80F0, 64);

        // R9 idle line
        wait_cyc(5);
        chk("R9", {31'h0, spi_miso}, 32'h0);

        finish_run();
    end

endmodule